// File: doc/BRIEF.md
# Programmable Flash Instruction Sequence Engine

This block is a single-lane SPI flash controller. It does not hard-code any transaction. Software loads a small table of packed 16-bit instructions through a word write port. It then writes a control word that names a sequence slot and a byte count, and starts the run by setting the trigger bit of a command write. The engine walks the sequence one instruction at a time. It drives chip select, the serial clock and the data line, and draws payload bytes from an internal transmit FIFO.

Each table word holds two instructions, and the low half runs first. Only three opcodes are meaningful: send an operand byte as a command, stream payload bytes from the FIFO, and stop. The payload length is taken from the control word, not from the instruction, so one table entry can serve writes of any size. At the end of a run the engine raises a one-cycle done pulse and a sticky done flag. An illegal instruction or a starved FIFO ends the run early and sets a sticky error flag.

Top module: `flash_seq_engine`

## Requirements
- R1: Table word address is slot*4 + word (slot 0..15, word 0..3). An instruction is 16 bits: opcode in [15:10], pad code in [9:8] and operand in [7:0]. Bits [15:0] of a word execute before bits [31:16], and the words of a slot run in rising address order.
- R2: A control write latches the slot from bits [19:16] and the payload length from bits [7:0]. A command write with bit 0 set starts the latched slot when the engine is idle. `busy` is high from the cycle after the start until the run ends.
- R3: Opcode 0x01 with pad code 0 drives `cs_n` low (if it is not low already) and shifts the operand byte out MSB first.
- R4: Opcode 0x08 with pad code 0 shifts out as many FIFO bytes as the latched length, in push order. With length 0 it sends nothing and the run moves to the next instruction.
- R5: An instruction whose opcode field is 0 ends the run and drives `cs_n` high.
- R6: If no stop instruction has run, the run ends by itself after the eighth instruction of the slot.
- R7: A nonzero opcode other than 0x01 or 0x08, or a nonzero pad code, ends the run, drives `cs_n` high and sets `err_flag`.
- R8: If the FIFO is empty when a payload byte is due, the run ends, `cs_n` goes high and `err_flag` is set.
- R9: The bus runs in SPI mode 0. `sclk` is low whenever `cs_n` is high, and `mosi` changes only while `sclk` is low. Each `sclk` phase lasts CLK_DIV system clocks, so one byte keeps `sclk` high for 8*CLK_DIV cycles.
- R10: A trigger written while `busy` is high is ignored. The current run is not disturbed and no second run follows.
- R11: At the end of each run `done_pulse` is high for one cycle, in the same cycle that `busy` falls, and `done_flag` is set. An accepted trigger clears both `done_flag` and `err_flag`.
- R12: After reset `cs_n` is 1, `sclk` and `mosi` are 0, `busy`, `done_pulse`, `done_flag` and `err_flag` are 0, and the FIFO is empty.
- R13: The FIFO holds FIFO_DEPTH bytes. `txf_full` is high when it is full, and a push while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | 6 | Table word address (slot*4 + word) |
| tbl_wdata | input | 32 | Table word data (two instructions) |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: slot in [19:16], length in [7:0] |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command data, bit 0 is the trigger |
| txf_push | input | 1 | Push a byte into the transmit FIFO |
| txf_data | input | 8 | Byte to push |
| txf_full | output | 1 | Transmit FIFO is full |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | A sequence is running |
| done_pulse | output | 1 | One-cycle pulse at end of sequence |
| done_flag | output | 1 | Sticky end-of-sequence flag |
| err_flag | output | 1 | Sticky abort flag |

## Verification
The bench goes after the execution order of the two halves of a word and across words. A design that swapped the halves or skipped a word would send the bytes in the wrong order. It runs an eight-instruction slot with no stop, where a missing instruction limit would keep fetching the next slot and emit extra bytes. The length-0 payload, the starved FIFO and the full FIFO show whether the design counts bytes from the control word, stalls or hangs where it should abort, and keeps or drops the overflow byte. A second trigger fired in the middle of a run would restart or chain a transaction in a design that failed to lock it out. The bench sees that as an extra chip-select frame or done pulse.

// File: rtl/flash_seq_engine.sv
module flash_seq_engine #(
  parameter int CLK_DIV    = 2,
  parameter int SEQ_NUM    = 16,
  parameter int SEQ_WORDS  = 4,
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_we,
  input  logic [5:0]  tbl_addr,
  input  logic [31:0] tbl_wdata,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        txf_push,
  input  logic [7:0]  txf_data,
  output logic        txf_full,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  output logic        busy,
  output logic        done_pulse,
  output logic        done_flag,
  output logic        err_flag
);
  localparam int SEQ_W   = $clog2(SEQ_NUM);
  localparam int WRD_W   = $clog2(SEQ_WORDS);
  localparam int TBL_N   = SEQ_NUM * SEQ_WORDS;
  localparam int INS_NUM = SEQ_WORDS * 2;
  localparam int INS_W   = $clog2(INS_NUM);
  localparam int DIV_W   = $clog2(CLK_DIV + 1);
  localparam int FP_W    = $clog2(FIFO_DEPTH);
  localparam int FC_W    = $clog2(FIFO_DEPTH + 1);
  localparam logic [5:0] OP_STOP = 6'h00;
  localparam logic [5:0] OP_CMD  = 6'h01;
  localparam logic [5:0] OP_WR   = 6'h08;

  typedef enum logic [1:0] {S_IDLE, S_DEC, S_SHIFT} state_t;

  // instruction table
  logic [31:0] tbl [TBL_N];
  always_ff @(posedge clk)
    if (tbl_we) tbl[tbl_addr[SEQ_W+WRD_W-1:0]] <= tbl_wdata;

  // control word
  logic [SEQ_W-1:0] seq_q;
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seq_q <= '0;
      len_q <= '0;
    end else if (ctl_we) begin
      seq_q <= ctl_wdata[16 +: SEQ_W];
      len_q <= ctl_wdata[LEN_W-1:0];
    end

  logic unused_bits;
  assign unused_bits = ^{ctl_wdata[31:16+SEQ_W], ctl_wdata[15:LEN_W], cmd_wdata[31:1], tbl_addr};

  // transmit FIFO
  logic [7:0]      fmem [FIFO_DEPTH];
  logic [FP_W-1:0] wptr, rptr;
  logic [FC_W-1:0] fcnt;
  logic            push_ok, pop, empty;
  logic [7:0]      head;

  assign txf_full = (fcnt == FC_W'(FIFO_DEPTH));
  assign empty    = (fcnt == '0);
  assign push_ok  = txf_push && !txf_full;
  assign head     = fmem[rptr];

  always_ff @(posedge clk)
    if (push_ok) fmem[wptr] <= txf_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fcnt <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == FP_W'(FIFO_DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)     rptr <= (rptr == FP_W'(FIFO_DEPTH-1)) ? '0 : rptr + 1'b1;
      fcnt <= fcnt + FC_W'(push_ok) - FC_W'(pop);
    end

  // sequencer state
  state_t           st;
  logic [SEQ_W-1:0] seq_r;
  logic [LEN_W-1:0] len_r;
  logic [INS_W-1:0] ins_idx;
  logic [7:0]       sh;
  logic [2:0]       bit_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             sclk_r, cs_r, is_data;

  logic [31:0] cur_word;
  logic [15:0] ins;
  logic [5:0]  opc;
  logic [1:0]  pad;
  logic        trig, tick, byte_end;
  logic        fin, fin_err, adv, load, load_data;
  logic [7:0]  load_byte;

  assign cur_word = tbl[{seq_r, ins_idx[INS_W-1:1]}];
  assign ins      = ins_idx[0] ? cur_word[31:16] : cur_word[15:0];
  assign opc      = ins[15:10];
  assign pad      = ins[9:8];
  assign trig     = cmd_we && cmd_wdata[0];
  assign tick     = (div_cnt == DIV_W'(CLK_DIV-1));
  assign byte_end = (st == S_SHIFT) && tick && sclk_r && (bit_cnt == 3'd7);

  always_comb begin
    fin = 1'b0; fin_err = 1'b0; adv = 1'b0;
    load = 1'b0; load_data = 1'b0; load_byte = '0; pop = 1'b0;
    if (st == S_DEC) begin
      if (opc == OP_STOP) fin = 1'b1;
      else if (pad != 2'd0) begin fin = 1'b1; fin_err = 1'b1; end
      else if (opc == OP_CMD) begin load = 1'b1; load_byte = ins[7:0]; end
      else if (opc == OP_WR) begin
        if (len_r == '0) adv = 1'b1;
        else if (empty) begin fin = 1'b1; fin_err = 1'b1; end
        else begin load = 1'b1; load_data = 1'b1; load_byte = head; pop = 1'b1; end
      end else begin fin = 1'b1; fin_err = 1'b1; end
    end
    if (byte_end) begin
      if (is_data && len_r > LEN_W'(1)) begin
        if (empty) begin fin = 1'b1; fin_err = 1'b1; end
        else begin load = 1'b1; load_data = 1'b1; load_byte = head; pop = 1'b1; end
      end else adv = 1'b1;
    end
    if (adv && ins_idx == INS_W'(INS_NUM-1)) fin = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; seq_r <= '0; len_r <= '0; ins_idx <= '0;
      sh <= '0; bit_cnt <= '0; div_cnt <= '0;
      sclk_r <= 1'b0; cs_r <= 1'b0; is_data <= 1'b0;
      done_pulse <= 1'b0; done_flag <= 1'b0; err_flag <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (byte_end && is_data) len_r <= len_r - 1'b1;
      if (st == S_IDLE) begin
        if (trig) begin
          seq_r <= seq_q; len_r <= len_q; ins_idx <= '0;
          done_flag <= 1'b0; err_flag <= 1'b0;
          st <= S_DEC;
        end
      end else if (fin) begin
        st <= S_IDLE; cs_r <= 1'b0; sclk_r <= 1'b0; sh <= '0;
        done_pulse <= 1'b1; done_flag <= 1'b1; err_flag <= fin_err;
      end else if (load) begin
        st <= S_SHIFT; cs_r <= 1'b1; sh <= load_byte; is_data <= load_data;
        bit_cnt <= '0; div_cnt <= '0; sclk_r <= 1'b0;
      end else if (adv) begin
        ins_idx <= ins_idx + 1'b1; sclk_r <= 1'b0; st <= S_DEC;
      end else if (st == S_SHIFT) begin
        if (tick) begin
          div_cnt <= '0;
          if (!sclk_r) sclk_r <= 1'b1;
          else begin
            sclk_r <= 1'b0; sh <= {sh[6:0], 1'b0}; bit_cnt <= bit_cnt + 1'b1;
          end
        end else div_cnt <= div_cnt + 1'b1;
      end
    end

  assign sclk = sclk_r;
  assign cs_n = ~cs_r;
  assign mosi = cs_r & sh[7];
  assign busy = (st != S_IDLE);

  // checks
  a_r5_cs_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> cs_n);
  a_r9_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r9_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  a_r10_trigger_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> $stable(seq_r) && busy);
  a_r11_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (cs_n && !busy && done_flag));
  a_r11_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_pulse);
  a_r13_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FC_W'(FIFO_DEPTH));
endmodule

// File: tb/flash_seq_engine_tb.sv
module flash_seq_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        tbl_we = 0, ctl_we = 0, cmd_we = 0, txf_push = 0;
  logic [5:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0, ctl_wdata = '0, cmd_wdata = '0;
  logic [7:0]  txf_data = '0;
  logic txf_full, sclk, cs_n, mosi, busy, done_pulse, done_flag, err_flag;

  flash_seq_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .txf_push(txf_push), .txf_data(txf_data), .txf_full(txf_full),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done_pulse(done_pulse),
    .done_flag(done_flag), .err_flag(err_flag));

  int checks = 0, failures = 0;

  // bus monitor
  logic [7:0] cap [0:255];
  logic [7:0] shreg = '0;
  int nbytes = 0, bitc = 0, frames = 0, dones = 0, hi_samples = 0, mosi_glitch = 0;
  logic prev_sclk = 0, prev_mosi = 0;

  always @(posedge sclk) if (!cs_n) begin
    shreg = {shreg[6:0], mosi};
    bitc++;
    if (bitc == 8) begin cap[nbytes % 256] = shreg; nbytes++; bitc = 0; end
  end
  always @(negedge cs_n) frames++;
  always @(negedge clk) begin
    if (done_pulse) dones++;
    if (sclk) hi_samples++;
    if (sclk && prev_sclk && mosi != prev_mosi) mosi_glitch++;
    prev_sclk = sclk; prev_mosi = mosi;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_tbl(input int a, input logic [31:0] d);
    @(negedge clk); tbl_we = 1; tbl_addr = 6'(a); tbl_wdata = d;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); txf_push = 1; txf_data = d;
    @(negedge clk); txf_push = 0;
  endtask

  task automatic wr_ctl(input int idx, input int len);
    @(negedge clk); ctl_we = 1; ctl_wdata = (32'(idx) << 16) | 32'(len);
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic trigger();
    @(negedge clk); cmd_we = 1; cmd_wdata = 32'h1;
    @(negedge clk); cmd_we = 0; cmd_wdata = 32'h0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  // idx, w0, w1, len, npush, nexp, b0, b1, err
  localparam int NV = 9;
  localparam logic [100:0] VEC [0:NV-1] = '{
    {4'd8,  32'h20040401, 32'h0,        8'd1, 4'd1, 4'd2, 8'h01, 8'hC0, 1'b0},
    {4'd3,  32'h00000406, 32'h0,        8'd0, 4'd0, 4'd1, 8'h06, 8'h00, 1'b0},
    {4'd15, 32'h20040402, 32'h0,        8'd3, 4'd3, 4'd4, 8'h02, 8'hC0, 1'b0},
    {4'd0,  32'h040B04AB, 32'h0,        8'd0, 4'd0, 4'd2, 8'hAB, 8'h0B, 1'b0},
    {4'd1,  32'h0C000405, 32'h0,        8'd0, 4'd0, 4'd1, 8'h05, 8'h00, 1'b1},
    {4'd2,  32'h20040401, 32'h0,        8'd2, 4'd1, 4'd2, 8'h01, 8'hC0, 1'b1},
    {4'd4,  32'h00000501, 32'h0,        8'd0, 4'd0, 4'd0, 8'h00, 8'h00, 1'b1},
    {4'd6,  32'h20040401, 32'h0,        8'd0, 4'd0, 4'd1, 8'h01, 8'h00, 1'b0},
    {4'd7,  32'h04220421, 32'h00000423, 8'd0, 4'd0, 4'd3, 8'h21, 8'h22, 1'b0}
  };

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi == 0, "R12 bus idle", {cs_n, sclk, mosi}, 3'b100);
    chk(!busy && !done_pulse && !done_flag && !err_flag, "R12 status clear",
        {busy, done_pulse, done_flag, err_flag}, 0);
    chk(!txf_full, "R12 fifo empty", txf_full, 0);

    // table-driven runs: R1 R3 R4 R5 R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      logic [100:0] e = VEC[v];
      int idx = int'(e[100:97]);
      int base, d0, f0;
      for (int k = 0; k < 4; k++)
        wr_tbl(idx * 4 + k, k == 0 ? e[96:65] : (k == 1 ? e[64:33] : 32'h0));
      for (int k = 0; k < int'(e[24:21]); k++) push(8'hC0 + 8'(k));
      wr_ctl(idx, int'(e[32:25]));
      base = nbytes; d0 = dones; f0 = frames;
      trigger();
      wait_idle();
      chk(nbytes - base == int'(e[20:17]), $sformatf("R1/R4 vec%0d byte count", v),
          nbytes - base, e[20:17]);
      if (e[20:17] >= 1)
        chk(cap[base % 256] == e[16:9], $sformatf("R3 vec%0d first byte", v), cap[base % 256], e[16:9]);
      if (e[20:17] >= 2)
        chk(cap[(base + 1) % 256] == e[8:1], $sformatf("R1/R4 vec%0d second byte", v),
            cap[(base + 1) % 256], e[8:1]);
      chk(err_flag == e[0], $sformatf("R7/R8 vec%0d err_flag", v), err_flag, e[0]);
      chk(done_flag && dones == d0 + 1, $sformatf("R11 vec%0d done", v), dones - d0, 1);
      chk(cs_n && !busy, $sformatf("R5 vec%0d cs released", v), cs_n, 1);
      chk(frames - f0 == (e[20:17] != 0 ? 1 : 0), $sformatf("R3 vec%0d one frame", v), frames - f0, 1);
    end

    // R9 timing of one command byte
    begin
      int h0;
      wr_tbl(40, 32'h000004A5);
      wr_tbl(41, 32'h0);
      wr_ctl(10, 0);
      h0 = hi_samples;
      trigger();
      wait_idle();
      chk(hi_samples - h0 == 16, "R9 sclk high cycles per byte", hi_samples - h0, 16);
      chk(mosi_glitch == 0, "R9 mosi stable while sclk high", mosi_glitch, 0);
      chk(cap[(nbytes - 1) % 256] == 8'hA5, "R3 MSB-first byte", cap[(nbytes - 1) % 256], 8'hA5);
    end

    // R6 eight instructions without stop, R10 trigger while busy
    begin
      int base, d0, f0;
      wr_tbl(20, 32'h04110410);
      wr_tbl(21, 32'h04130412);
      wr_tbl(22, 32'h04150414);
      wr_tbl(23, 32'h04170416);
      wr_tbl(24, 32'h04EE04EE);
      wr_ctl(5, 0);
      base = nbytes; d0 = dones; f0 = frames;
      trigger();
      repeat (20) @(negedge clk);
      chk(busy, "R2 busy during run", busy, 1);
      wr_ctl(8, 1);
      trigger();
      wait_idle();
      repeat (60) @(negedge clk);
      chk(nbytes - base == 8, "R6 auto stop after eighth", nbytes - base, 8);
      chk(cap[(base + 7) % 256] == 8'h17, "R6 last byte", cap[(base + 7) % 256], 8'h17);
      chk(frames - f0 == 1, "R10 no second frame", frames - f0, 1);
      chk(dones - d0 == 1, "R10 single done pulse", dones - d0, 1);
      chk(!err_flag, "R6 no error", err_flag, 0);
    end

    // R13 full FIFO drops overflow, then starved payload
    begin
      int base;
      for (int k = 0; k < 9; k++) begin
        if (k == 8) chk(txf_full, "R13 full after depth pushes", txf_full, 1);
        push(8'hD0 + 8'(k));
      end
      wr_tbl(36, 32'h00002000);
      wr_tbl(37, 32'h0);
      wr_ctl(9, 9);
      base = nbytes;
      trigger();
      wait_idle();
      chk(nbytes - base == 8, "R13 dropped push not sent", nbytes - base, 8);
      chk(cap[(base + 7) % 256] == 8'hD7, "R13 last kept byte", cap[(base + 7) % 256], 8'hD7);
      chk(err_flag, "R8 underflow after drain", err_flag, 1);
      chk(!txf_full, "R13 full clears", txf_full, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule